// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Hundredths

This block is the counting core of a real-time clock. It holds the time and date as eight 8-bit BCD registers: hundredths, seconds, minutes, hours, day of week, date, month and year. Each pulse on a 100 Hz tick enable advances the hundredths count by one. Carries ripple up through the seconds, minutes, hours and calendar fields. The month length is taken from the month and the year, leap years included. The hours register supports a 12-hour or a 24-hour format.

A host moves the whole register set as one 64-bit image. A load replaces all eight registers in a single clock. A snapshot copies all eight registers into an output holding register at a single clock edge, so the host never sees a half-updated time. The day register also carries two control flags. One stops the count. The other decides whether an external active-low reset input may abort a host transfer. The design has no state machine: on every clock the register bank either loads, advances by one tick, or holds.

Top module: `rtc_bcd_core`

## Requirements
- R1: In the 64-bit image, register i occupies bits [8i+7:8i]. The registers are 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year. A load replaces all registers in the clock it is sampled, and a later snapshot returns the masked image.
- R2: Each tick with the clock running adds one to hundredths. Hundredths wrap from 99 to 00 and carry into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R3: When hours bit 7 is 0 the register is in 24-hour format. Bits 5:0 then hold BCD 00 to 23, and 23 wraps to 00 with a carry into day and date.
- R4: When hours bit 7 is 1 the register is in 12-hour format. Bit 5 is PM (1 = PM) and bits 4:0 hold 12, 01 … 11. The step from 11 to 12 toggles PM. A step from 11 PM to 12 AM carries into day and date.
- R5: The day of week sits in day bits 2:0. It counts 1 to 7 and wraps from 7 to 1 on each day carry.
- R6: Date bits 5:0 wrap to 01 after 30 in months 04, 06, 09 and 11. In every other month except 02 they wrap after 31. The wrap carries into the month.
- R7: In month 02 the date wraps after 29 when the year is divisible by 4, with year 00 counted as divisible. Otherwise it wraps after 28.
- R8: Month bits 4:0 wrap from 12 to 01 and carry into the year. The year wraps from 99 to 00.
- R9: While day bit 5 is 1, ticks change no register.
- R10: While day bit 4 is 1, `xfer_abort_o` stays 0 whatever the level of `ext_rst_n_i`. While it is 0, `xfer_abort_o` is 1 exactly when `ext_rst_n_i` is low.
- R11: After reset the image reads 64'h0001013100000000. This means 00:00:00.00 in 24-hour format, day 1 with day bits 5 and 4 both set, date 01, month 01, year 00.
- R12: The unused bits always read 0 and accept any value on a load. Per register, the kept bits are 1 = 7F, 2 = 7F, 3 = BF, 4 = 37, 5 = 3F and 6 = 1F.
- R13: A load takes priority over a tick in the same clock. A snapshot taken in the same clock as a tick returns the values from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 100 Hz advance enable, one clock wide |
| load_en_i | input | 1 | Load the full image from `load_img_i` |
| load_img_i | input | 64 | Image to load |
| snap_en_i | input | 1 | Capture the current registers into `snap_img_o` |
| snap_img_o | output | 64 | Last captured image |
| ext_rst_n_i | input | 1 | External active-low transfer-abort request |
| xfer_abort_o | output | 1 | Abort request passed on to the host transfer logic |

## Verification
The bench targets every rollover boundary: 23:59:59.99 in both hour formats, the 12-hour transitions at 11 AM, 11 PM and 12 AM, the 30-day and 31-day months, February in leap years (year 00 included) and in common years, and the rollover from 99 to 00 at New Year. A design with the wrong leap rule would stop February at the wrong date. A design that toggles PM on the wrong step would report noon as midnight, or would advance the date at noon. The bench also drives a load and a tick in the same clock, and a snapshot and a tick in the same clock. A design with the wrong priority would return an image that is off by one hundredth. Loading all ones shows whether the unused bits are masked. With the stop flag set, several ticks must leave the registers unchanged.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
    localparam int NREG  = 8;
    localparam int RW    = 8;
    localparam int IMG_W = NREG * RW;

    typedef logic [NREG-1:0][RW-1:0] bank_t;

    localparam int IX_HUND = 0;
    localparam int IX_SEC  = 1;
    localparam int IX_MIN  = 2;
    localparam int IX_HOUR = 3;
    localparam int IX_DAY  = 4;
    localparam int IX_DATE = 5;
    localparam int IX_MON  = 6;
    localparam int IX_YEAR = 7;

    localparam int HOUR_FMT12_BIT = 7;
    localparam int HOUR_PM_BIT    = 5;
    localparam int DAY_HALT_BIT   = 5;
    localparam int DAY_IGN_BIT    = 4;

    // kept bits per register, year first
    localparam bank_t KEEP_MASK  = {8'hFF, 8'h1F, 8'h3F, 8'h37, 8'hBF, 8'h7F, 8'h7F, 8'hFF};
    localparam bank_t RESET_BANK = {8'h00, 8'h01, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // returns {wrapped, next value}
    function automatic logic [8:0] bcd_wrap(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v >= last) return {1'b1, first};
        else           return {1'b0, bcd_inc(v)};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else              return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_bcd_pkg::*;
(
    input  bank_t cur_i,
    output bank_t nxt_o
);
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic [8:0] w_hund, w_sec, w_min, w_h24, w_date, w_mon;
    logic [7:0] hr12, hr12_n, day_b, day_n;
    logic       pm, pm_n;

    always_comb begin
        nxt_o  = cur_i;
        c_sec  = 1'b0;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        hr12   = cur_i[IX_HOUR] & 8'h1F;
        hr12_n = hr12;
        pm     = cur_i[IX_HOUR][HOUR_PM_BIT];
        pm_n   = pm;
        day_b  = cur_i[IX_DAY] & 8'h07;
        day_n  = (day_b >= 8'h07) ? 8'h01 : day_b + 8'h01;

        w_hund = bcd_wrap(cur_i[IX_HUND], 8'h99, 8'h00);
        w_sec  = bcd_wrap(cur_i[IX_SEC] & 8'h7F, 8'h59, 8'h00);
        w_min  = bcd_wrap(cur_i[IX_MIN] & 8'h7F, 8'h59, 8'h00);
        w_h24  = bcd_wrap(cur_i[IX_HOUR] & 8'h3F, 8'h23, 8'h00);
        w_date = bcd_wrap(cur_i[IX_DATE] & 8'h3F,
                          month_last(cur_i[IX_MON], cur_i[IX_YEAR]), 8'h01);
        w_mon  = bcd_wrap(cur_i[IX_MON] & 8'h1F, 8'h12, 8'h01);

        nxt_o[IX_HUND] = w_hund[7:0];
        c_sec          = w_hund[8];

        if (c_sec) begin
            nxt_o[IX_SEC] = w_sec[7:0];
            c_min         = w_sec[8];
        end
        if (c_min) begin
            nxt_o[IX_MIN] = w_min[7:0];
            c_hour        = w_min[8];
        end
        if (c_hour) begin
            if (cur_i[IX_HOUR][HOUR_FMT12_BIT]) begin
                if (hr12 >= 8'h12) begin
                    hr12_n = 8'h01;
                end else if (hr12 == 8'h11) begin
                    hr12_n = 8'h12;
                    pm_n   = ~pm;
                    c_day  = pm;
                end else begin
                    hr12_n = bcd_inc(hr12);
                end
                nxt_o[IX_HOUR] = {2'b10, pm_n, hr12_n[4:0]};
            end else begin
                nxt_o[IX_HOUR] = w_h24[7:0];
                c_day          = w_h24[8];
            end
        end
        if (c_day) begin
            nxt_o[IX_DAY]  = (cur_i[IX_DAY] & 8'h30) | day_n;
            nxt_o[IX_DATE] = w_date[7:0];
            c_mon          = w_date[8];
        end
        if (c_mon) begin
            nxt_o[IX_MON] = w_mon[7:0];
            c_year        = w_mon[8];
        end
        if (c_year) begin
            nxt_o[IX_YEAR] = (cur_i[IX_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cur_i[IX_YEAR]);
        end
    end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
    import rtc_bcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  load_en_i,
    input  bank_t load_i,
    input  bank_t nxt_i,
    input  logic  snap_en_i,
    output bank_t cur_o,
    output bank_t snap_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_o <= RESET_BANK;
        end else if (load_en_i) begin
            cur_o <= load_i & KEEP_MASK;
        end else if (tick_i && !cur_o[IX_DAY][DAY_HALT_BIT]) begin
            cur_o <= nxt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_o <= '0;
        end else if (snap_en_i) begin
            snap_o <= cur_o;
        end
    end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_bcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_en_i,
    input  logic [IMG_W-1:0] load_img_i,
    input  logic             snap_en_i,
    output logic [IMG_W-1:0] snap_img_o,
    input  logic             ext_rst_n_i,
    output logic             xfer_abort_o
);
    bank_t cur_bank, nxt_bank, snap_bank, load_bank;

    assign load_bank  = load_img_i;
    assign snap_img_o = snap_bank;

    rtc_calendar_next u_next (
        .cur_i (cur_bank),
        .nxt_o (nxt_bank)
    );

    rtc_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .load_en_i (load_en_i),
        .load_i    (load_bank),
        .nxt_i     (nxt_bank),
        .snap_en_i (snap_en_i),
        .cur_o     (cur_bank),
        .snap_o    (snap_bank)
    );

    assign xfer_abort_o = !ext_rst_n_i && !cur_bank[IX_DAY][DAY_IGN_BIT];
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_bcd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             load_en_i,
    input logic [IMG_W-1:0] load_img_i,
    input logic             snap_en_i,
    input logic [IMG_W-1:0] snap_img_o,
    input logic             xfer_abort_o,
    input bank_t            cur_bank
);
    logic runs;
    assign runs = tick_i && !load_en_i && !cur_bank[IX_DAY][DAY_HALT_BIT];

    // R1: a load lands whole, masked, in the next cycle
    p_load_whole_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> (cur_bank == ($past(load_img_i) & KEEP_MASK)));

    // R2: hundredths wrap to zero after 99
    p_hund_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (runs && cur_bank[IX_HUND] == 8'h99) |=> (cur_bank[IX_HUND] == 8'h00));

    // R9: halted clock ignores ticks
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_en_i && cur_bank[IX_DAY][DAY_HALT_BIT]) |=> $stable(cur_bank));

    // R10: ignore flag suppresses the abort output
    p_ignore_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank[IX_DAY][DAY_IGN_BIT] |-> !xfer_abort_o);

    // R12: unused bits never appear in a snapshot
    p_zero_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_img_o & ~KEEP_MASK) == '0);

    // R13: a snapshot holds the pre-edge register values
    p_snap_coherent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en_i |=> (snap_img_o == $past(cur_bank)));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .load_en_i    (load_en_i),
    .load_img_i   (load_img_i),
    .snap_en_i    (snap_en_i),
    .snap_img_o   (snap_img_o),
    .xfer_abort_o (xfer_abort_o),
    .cur_bank     (cur_bank)
);

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_img = '0;
    logic        snap_en = 1'b0;
    logic [63:0] snap_img;
    logic        ext_rst_n = 1'b0;
    logic        abort;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rtc_bcd_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .load_en_i    (load_en),
        .load_img_i   (load_img),
        .snap_en_i    (snap_en),
        .snap_img_o   (snap_img),
        .ext_rst_n_i  (ext_rst_n),
        .xfer_abort_o (abort)
    );

    function automatic logic [63:0] mk(input logic [7:0] y, mo, da, dw, hr, mi, se, hu);
        return {y, mo, da, dw, hr, mi, se, hu};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk); load_en = 1'b1; load_img = v;
        @(negedge clk); load_en = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_snap(output logic [63:0] v);
        @(negedge clk); snap_en = 1'b1;
        @(negedge clk); snap_en = 1'b0;
        v = snap_img;
    endtask

    task automatic step_once(input string tag, input logic [63:0] vin, input logic [63:0] vexp);
        logic [63:0] s;
        do_load(vin);
        do_tick(1);
        do_snap(s);
        chk(tag, s, vexp);
    endtask

    task automatic t_reset();
        logic [63:0] s;
        do_snap(s);
        chk("R11 reset image", s, 64'h0001013100000000);
        chk("R10 abort ignored after reset", {63'd0, abort}, 64'd0);
        do_tick(3);
        do_snap(s);
        chk("R9 halted after reset", s, 64'h0001013100000000);
    endtask

    task automatic t_mask();
        logic [63:0] s;
        do_load({64{1'b1}});
        do_snap(s);
        chk("R12 R1 all-ones load masked", s, 64'hFF1F3F37BF7F7FFF);
    endtask

    task automatic t_carry();
        logic [63:0] s;
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h59, 8'h59, 8'h98));
        do_tick(1);
        do_snap(s);
        chk("R2 hundredths step", s, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h59, 8'h59, 8'h99));
        do_tick(1);
        do_snap(s);
        chk("R2 carry to hour", s, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h11, 8'h00, 8'h00, 8'h00));
        step_once("R2 seconds to minute",
                  mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h59, 8'h99),
                  mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h21, 8'h00, 8'h00));
    endtask

    task automatic t_calendar();
        step_once("R3 R5 R6 midnight 30-day month",
                  mk(8'h23, 8'h04, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h23, 8'h05, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R6 31-day month continues",
                  mk(8'h23, 8'h05, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h23, 8'h05, 8'h31, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 leap 24 feb 28",
                  mk(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 leap 24 feb 29",
                  mk(8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 common 23 feb 28",
                  mk(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h23, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 year 00 leap",
                  mk(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 year 12 leap",
                  mk(8'h12, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h12, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R7 year 10 common",
                  mk(8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h10, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_once("R8 new year and century",
                  mk(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59, 8'h99),
                  mk(8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_12h();
        step_once("R4 11 AM to 12 PM",
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'hB2, 8'h00, 8'h00, 8'h00));
        step_once("R4 11 PM to 12 AM next day",
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h06, 8'h11, 8'h03, 8'h92, 8'h00, 8'h00, 8'h00));
        step_once("R4 12 AM to 01 AM",
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'h92, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'h81, 8'h00, 8'h00, 8'h00));
        step_once("R4 09 PM to 10 PM",
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'hA9, 8'h59, 8'h59, 8'h99),
                  mk(8'h24, 8'h06, 8'h10, 8'h02, 8'hB0, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_halt();
        logic [63:0] s;
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h23, 8'h10, 8'h20, 8'h30, 8'h40));
        do_tick(5);
        do_snap(s);
        chk("R9 halt flag freezes", s, mk(8'h24, 8'h03, 8'h15, 8'h23, 8'h10, 8'h20, 8'h30, 8'h40));
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30, 8'h40));
        do_tick(3);
        do_snap(s);
        chk("R9 running after clear", s, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30, 8'h43));
    endtask

    task automatic t_abort();
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h11, 8'h10, 8'h20, 8'h30, 8'h40));
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R10 ignore set, ext low", {63'd0, abort}, 64'd0);
        ext_rst_n = 1'b1;
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h01, 8'h10, 8'h20, 8'h30, 8'h40));
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R10 ignore clear, ext low", {63'd0, abort}, 64'd1);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ignore clear, ext high", {63'd0, abort}, 64'd0);
    endtask

    task automatic t_priority();
        logic [63:0] s;
        logic [63:0] a;
        a = mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30, 8'h10);
        @(negedge clk); load_en = 1'b1; load_img = a; tick = 1'b1;
        @(negedge clk); load_en = 1'b0; tick = 1'b0;
        do_snap(s);
        chk("R13 load wins over tick", s, a);
        @(negedge clk); snap_en = 1'b1; tick = 1'b1;
        @(negedge clk); snap_en = 1'b0; tick = 1'b0;
        chk("R13 snapshot before tick", snap_img, a);
        do_snap(s);
        chk("R13 tick applied after", s, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h20, 8'h30, 8'h11));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        ext_rst_n = 1'b1;
        t_mask();
        t_carry();
        t_calendar();
        t_12h();
        t_halt();
        t_abort();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule